// File: doc/BRIEF.md
# Programmable Polynomial Remainder Unit

This unit reduces a polynomial product over GF(2) modulo a generator polynomial of any degree from 1 to 32. The product arrives as a 63-bit word. The bits below the generator degree `d` pass through unchanged. Each set bit at position `d + j` adds row `j` of a reduction matrix, and row `j` holds the remainder of `x^(d+j)`. The unit registers the result once, so a remainder follows every valid product by one clock.

The unit keeps two banks, and each bank holds 31 rows of 32 bits and a degree. The active bank serves the reductions. The other bank, the shadow, takes loads while reductions carry on. A host can write the shadow one row per clock, or it can start the built-in fill sequencer, which derives all rows from the polynomial. A swap pulse exchanges the roles of the two banks at the next clock edge.

The fill sequencer has two states:
- `GEN_IDLE` waits. A `gen_start` pulse takes the transition *launch*: it writes the shadow degree and enters `GEN_FILL`.
- `GEN_FILL` writes row `cnt` on every clock. After row 30 it takes the transition *finish* back to `GEN_IDLE` and raises `gen_done` for one clock.

Top module: `crc_reducer`

## Requirements
- R1: When `in_valid` is high at a clock edge, `out_valid` is high in the following cycle and `out_rem` equals `in_prod` mod p for the active bank. When `in_valid` is low, `out_valid` is low in the following cycle.
- R2: If `in_prod` has no bit set at or above the active degree `d`, then `out_rem` equals `in_prod`.
- R3: Bits of `in_prod` at positions `d+31` and above have no effect on `out_rem`.
- R4: `ld_row_we` with index `j` < 31 writes `ld_row_data` into row `j` of the shadow bank. `ld_deg_we` writes the shadow degree. An index of 31 is ignored. No shadow write changes results until a swap.
- R5: A `swap` pulse makes the shadow bank active from the next clock edge. A product presented in the same cycle as the swap uses the old bank. The previously active bank keeps its contents, so a second swap restores it.
- R6: `gen_start` in `GEN_IDLE` sets the shadow degree to `gen_deg`. It then fills shadow rows 0..30 with `x^(d+j)` mod p over 31 cycles with `gen_busy` high. `gen_done` is high for exactly one cycle after that. `gen_poly` bit `i` is the coefficient of `x^i`, and `x^d` is implied.
- R7: While `gen_busy` is high, and in the cycle of an accepted `gen_start`, host row writes, host degree writes, `swap` and further `gen_start` pulses are ignored.
- R8: After reset, `out_valid` is low. Both banks hold degree 32 and all-zero rows, so a reduction returns `in_prod[31:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Product valid |
| in_prod | input | 63 | Product polynomial, bit i = coefficient of x^i |
| out_valid | output | 1 | Remainder valid |
| out_rem | output | 32 | Remainder |
| ld_row_we | input | 1 | Host write of one shadow row |
| ld_row_idx | input | 5 | Row index for the host write |
| ld_row_data | input | 32 | Row contents |
| ld_deg_we | input | 1 | Host write of the shadow degree |
| ld_deg | input | 6 | Degree value, 1..32 |
| swap | input | 1 | Exchange active and shadow banks |
| gen_start | input | 1 | Start the fill sequencer |
| gen_poly | input | 32 | Generator coefficients below x^d |
| gen_deg | input | 6 | Generator degree, 1..32 |
| gen_busy | output | 1 | Sequencer is filling rows |
| gen_done | output | 1 | One-cycle pulse after the last row |

## Verification
The assertions assume the following about the inputs:
- Every degree lies in 1..32.
- Every row a host writes has no bits at or above the degree of its bank.
- `gen_poly` has no bits at or above `gen_deg`, so the sequencer's rows stay inside the degree mask.

The stimulus computes every host row with its own long-division function. It draws degrees only from valid values and masks random polynomials to their degree. Random products are masked to `d+31` bits, except for the directed cases that set bits above that boundary to check R3.

// File: rtl/crc_red_pkg.sv
package crc_red_pkg;

    typedef enum logic [0:0] {
        GEN_IDLE = 1'b0,
        GEN_FILL = 1'b1
    } gen_state_e;

endpackage

// File: rtl/crc_red_bank.sv
module crc_red_bank #(
    parameter int DEG_MAX = 32,
    parameter int ROWS    = 31,
    parameter int IDX_W   = 5,
    parameter int DEG_W   = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            row_we,
    input  logic [IDX_W-1:0]                row_idx,
    input  logic [DEG_MAX-1:0]              row_data,
    input  logic                            deg_we,
    input  logic [DEG_W-1:0]                deg_data,
    input  logic                            swap_i,
    output logic [ROWS-1:0][DEG_MAX-1:0]    act_rows_o,
    output logic [DEG_W-1:0]                act_deg_o
);

    logic [ROWS-1:0][DEG_MAX-1:0] bank_q [2];
    logic [DEG_W-1:0]             deg_q  [2];
    logic                         sel_q;
    logic                         shd;

    assign shd = ~sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q     <= 1'b0;
            bank_q[0] <= '0;
            bank_q[1] <= '0;
            deg_q[0]  <= DEG_W'(DEG_MAX);
            deg_q[1]  <= DEG_W'(DEG_MAX);
        end else begin
            if (row_we && (int'(row_idx) < ROWS)) begin
                bank_q[shd][row_idx] <= row_data;
            end
            if (deg_we) begin
                deg_q[shd] <= deg_data;
            end
            if (swap_i) begin
                sel_q <= ~sel_q;
            end
        end
    end

    assign act_rows_o = bank_q[sel_q];
    assign act_deg_o  = deg_q[sel_q];

    AST_SWAP_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        swap_i |=> (sel_q != $past(sel_q))); // R5
    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_i |=> ($stable(act_rows_o) && $stable(act_deg_o))); // R4

endmodule

// File: rtl/crc_red_gen.sv
module crc_red_gen
    import crc_red_pkg::*;
#(
    parameter int DEG_MAX = 32,
    parameter int ROWS    = 31,
    parameter int IDX_W   = 5,
    parameter int DEG_W   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [DEG_MAX-1:0]  poly_i,
    input  logic [DEG_W-1:0]    deg_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                row_we_o,
    output logic [IDX_W-1:0]    row_idx_o,
    output logic [DEG_MAX-1:0]  row_data_o,
    output logic                deg_we_o,
    output logic [DEG_W-1:0]    deg_o
);

    gen_state_e         state_q, state_d;
    logic [IDX_W-1:0]   cnt_q;
    logic [DEG_MAX-1:0] cur_q, cur_next;
    logic [DEG_MAX-1:0] poly_q;
    logic [DEG_MAX-1:0] mask_q;
    logic [DEG_MAX-1:0] start_mask;
    logic [DEG_MAX-1:0] top_bit;
    logic               last_row;
    logic               done_q;

    assign start_mask = ~({DEG_MAX{1'b1}} << deg_i);
    assign top_bit    = mask_q ^ (mask_q >> 1);
    assign last_row   = (int'(cnt_q) == ROWS - 1);

    always_comb begin
        cur_next = (cur_q << 1) & mask_q;
        if (|(cur_q & top_bit)) begin
            cur_next = cur_next ^ poly_q;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GEN_IDLE: if (start_i)  state_d = GEN_FILL;
            GEN_FILL: if (last_row) state_d = GEN_IDLE;
            default:                state_d = GEN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GEN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            cur_q  <= '0;
            poly_q <= '0;
            mask_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == GEN_FILL) && last_row;
            if (state_q == GEN_IDLE && start_i) begin
                cnt_q  <= '0;
                cur_q  <= poly_i & start_mask;
                poly_q <= poly_i & start_mask;
                mask_q <= start_mask;
            end else if (state_q == GEN_FILL) begin
                cnt_q <= cnt_q + 1'b1;
                cur_q <= cur_next;
            end
        end
    end

    always_comb begin
        busy_o     = 1'b0;
        row_we_o   = 1'b0;
        deg_we_o   = 1'b0;
        unique case (state_q)
            GEN_IDLE: deg_we_o = start_i;
            GEN_FILL: begin
                busy_o   = 1'b1;
                row_we_o = 1'b1;
            end
            default: ;
        endcase
        row_idx_o  = cnt_q;
        row_data_o = cur_q;
        deg_o      = deg_i;
        done_o     = done_q;
    end

    AST_GEN_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (int'(cnt_q) < ROWS)); // R6
    AST_GEN_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_GEN_ROW_IN_DEG: assert property (@(posedge clk) disable iff (!rst_n)
        row_we_o |-> ((row_data_o & ~mask_q) == '0)); // R6
    AST_GEN_DONE_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o); // R6

endmodule

// File: rtl/crc_red_core.sv
module crc_red_core #(
    parameter int DEG_MAX = 32,
    parameter int PROD_W  = 63,
    parameter int ROWS    = 31,
    parameter int DEG_W   = 6,
    parameter int POS_W   = 7
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic [PROD_W-1:0]               in_prod,
    input  logic [ROWS-1:0][DEG_MAX-1:0]    rows_i,
    input  logic [DEG_W-1:0]                deg_i,
    output logic                            out_valid,
    output logic [DEG_MAX-1:0]              out_rem
);

    logic [DEG_MAX-1:0] low_mask;
    logic [DEG_MAX-1:0] acc;
    logic [DEG_MAX-1:0] cap_mask_q;

    assign low_mask = ~({DEG_MAX{1'b1}} << deg_i);

    always_comb begin
        acc = in_prod[DEG_MAX-1:0] & low_mask;
        for (int j = 0; j < ROWS; j++) begin
            logic [POS_W-1:0] pos;
            pos = POS_W'(deg_i) + POS_W'(j);
            if ((int'(pos) < PROD_W) && in_prod[pos[POS_W-2:0]]) begin
                acc = acc ^ rows_i[j];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_rem    <= '0;
            cap_mask_q <= '1;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_rem    <= acc;
                cap_mask_q <= low_mask;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_REM_IN_DEG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_rem & ~cap_mask_q) == '0)); // R1

endmodule

// File: rtl/crc_reducer.sv
module crc_reducer #(
    parameter int DEG_MAX = 32,
    parameter int PROD_W  = 2 * DEG_MAX - 1,
    parameter int ROWS    = PROD_W - DEG_MAX,
    parameter int IDX_W   = $clog2(ROWS + 1),
    parameter int DEG_W   = $clog2(DEG_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [PROD_W-1:0]   in_prod,
    output logic                out_valid,
    output logic [DEG_MAX-1:0]  out_rem,
    input  logic                ld_row_we,
    input  logic [IDX_W-1:0]    ld_row_idx,
    input  logic [DEG_MAX-1:0]  ld_row_data,
    input  logic                ld_deg_we,
    input  logic [DEG_W-1:0]    ld_deg,
    input  logic                swap,
    input  logic                gen_start,
    input  logic [DEG_MAX-1:0]  gen_poly,
    input  logic [DEG_W-1:0]    gen_deg,
    output logic                gen_busy,
    output logic                gen_done
);

    localparam int POS_W = $clog2(PROD_W + 1) + 1;

    logic                         g_row_we, g_deg_we;
    logic [IDX_W-1:0]             g_row_idx;
    logic [DEG_MAX-1:0]           g_row_data;
    logic [DEG_W-1:0]             g_deg;
    logic                         claim;
    logic                         b_row_we, b_deg_we, b_swap;
    logic [IDX_W-1:0]             b_row_idx;
    logic [DEG_MAX-1:0]           b_row_data;
    logic [DEG_W-1:0]             b_deg;
    logic [ROWS-1:0][DEG_MAX-1:0] act_rows;
    logic [DEG_W-1:0]             act_deg;

    crc_red_gen #(
        .DEG_MAX(DEG_MAX), .ROWS(ROWS), .IDX_W(IDX_W), .DEG_W(DEG_W)
    ) i_gen (
        .clk(clk), .rst_n(rst_n),
        .start_i(gen_start), .poly_i(gen_poly), .deg_i(gen_deg),
        .busy_o(gen_busy), .done_o(gen_done),
        .row_we_o(g_row_we), .row_idx_o(g_row_idx), .row_data_o(g_row_data),
        .deg_we_o(g_deg_we), .deg_o(g_deg)
    );

    assign claim = gen_busy | gen_start;

    always_comb begin
        if (claim) begin
            b_row_we   = g_row_we;
            b_row_idx  = g_row_idx;
            b_row_data = g_row_data;
            b_deg_we   = g_deg_we;
            b_deg      = g_deg;
            b_swap     = 1'b0;
        end else begin
            b_row_we   = ld_row_we;
            b_row_idx  = ld_row_idx;
            b_row_data = ld_row_data;
            b_deg_we   = ld_deg_we;
            b_deg      = ld_deg;
            b_swap     = swap;
        end
    end

    crc_red_bank #(
        .DEG_MAX(DEG_MAX), .ROWS(ROWS), .IDX_W(IDX_W), .DEG_W(DEG_W)
    ) i_bank (
        .clk(clk), .rst_n(rst_n),
        .row_we(b_row_we), .row_idx(b_row_idx), .row_data(b_row_data),
        .deg_we(b_deg_we), .deg_data(b_deg), .swap_i(b_swap),
        .act_rows_o(act_rows), .act_deg_o(act_deg)
    );

    crc_red_core #(
        .DEG_MAX(DEG_MAX), .PROD_W(PROD_W), .ROWS(ROWS), .DEG_W(DEG_W), .POS_W(POS_W)
    ) i_core (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_prod(in_prod),
        .rows_i(act_rows), .deg_i(act_deg),
        .out_valid(out_valid), .out_rem(out_rem)
    );

    AST_BUSY_HOLDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        gen_busy |=> $stable(act_deg)); // R7

endmodule

// File: tb/test_crc_reducer.sv
module test_crc_reducer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [62:0] in_prod = '0;
    logic        out_valid;
    logic [31:0] out_rem;
    logic        ld_row_we = 1'b0;
    logic [4:0]  ld_row_idx = '0;
    logic [31:0] ld_row_data = '0;
    logic        ld_deg_we = 1'b0;
    logic [5:0]  ld_deg = '0;
    logic        swap = 1'b0;
    logic        gen_start = 1'b0;
    logic [31:0] gen_poly = '0;
    logic [5:0]  gen_deg = '0;
    logic        gen_busy;
    logic        gen_done;

    int checks = 0;
    int errors = 0;
    int unsigned seed = 32'd2024;

    always #(CLK_PERIOD / 2) clk = ~clk;

    crc_reducer i_crc_reducer (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_prod(in_prod),
        .out_valid(out_valid), .out_rem(out_rem),
        .ld_row_we(ld_row_we), .ld_row_idx(ld_row_idx), .ld_row_data(ld_row_data),
        .ld_deg_we(ld_deg_we), .ld_deg(ld_deg), .swap(swap),
        .gen_start(gen_start), .gen_poly(gen_poly), .gen_deg(gen_deg),
        .gen_busy(gen_busy), .gen_done(gen_done)
    );

    function automatic logic [31:0] polymod(logic [62:0] t, logic [31:0] poly, int d);
        logic [62:0] p = {31'b0, poly};
        for (int i = 62; i >= d; i--) begin
            if (t[i]) begin
                t[i] = 1'b0;
                t = t ^ (p << (i - d));
            end
        end
        return t[31:0];
    endfunction

    function automatic logic [62:0] prod_mask(int d);
        return (63'h1 << (d + 31)) - 63'h1;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reduce(logic [62:0] t, logic swap_too);
        @(negedge clk);
        in_valid = 1'b1;
        in_prod  = t;
        swap     = swap_too;
        @(negedge clk);
        in_valid = 1'b0;
        swap     = 1'b0;
    endtask

    task automatic red_check(string req, logic [62:0] t, logic [31:0] exp);
        reduce(t, 1'b0);
        check({req, " valid"}, 64'(out_valid), 64'd1);
        check(req, 64'(out_rem), 64'(exp));
    endtask

    task automatic host_load(logic [31:0] poly, int d);
        @(negedge clk);
        ld_deg_we = 1'b1;
        ld_deg    = 6'(d);
        for (int j = 0; j < 31; j++) begin
            @(negedge clk);
            ld_deg_we   = 1'b0;
            ld_row_we   = 1'b1;
            ld_row_idx  = 5'(j);
            ld_row_data = polymod(63'h1 << (d + j), poly, d);
        end
        @(negedge clk);
        ld_row_we   = 1'b0;
        ld_row_idx  = 5'd31;
        ld_row_data = 32'hFFFF_FFFF;
        ld_row_we   = 1'b1;
        @(negedge clk);
        ld_row_we = 1'b0;
    endtask

    task automatic pulse_swap();
        @(negedge clk);
        swap = 1'b1;
        @(negedge clk);
        swap = 1'b0;
    endtask

    task automatic random_checks(string req, logic [31:0] poly, int d, int n);
        for (int k = 0; k < n; k++) begin
            logic [62:0] t;
            t = {$urandom, $urandom} & prod_mask(d);
            red_check(req, t, polymod(t, poly, d));
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [62:0] t;
        int busy_cycles;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 out_valid low", 64'(out_valid), 64'd0);
        check("R8 gen_busy low", 64'(gen_busy), 64'd0);
        rst_n = 1'b1;
        t = {$urandom, $urandom};
        red_check("R8 reset passthrough", t, t[31:0]);

        // R4 host load of degree 8 into shadow, no effect before swap
        host_load(32'h07, 8);
        t = {$urandom, $urandom};
        red_check("R4 shadow write no effect", t, t[31:0]);
        pulse_swap();
        random_checks("R1 deg8", 32'h07, 8, 30);
        // R4 index 31 write was ignored: results still match
        red_check("R4 idx31 ignored", 63'h7F_FFFF_FFFF, polymod(63'h7F_FFFF_FFFF, 32'h07, 8));
        // R2 below degree
        red_check("R2 low passthrough", 63'hA5, 32'hA5);
        // R3 bits at d+31 and up ignored
        t = {$urandom, $urandom} & prod_mask(8);
        red_check("R3 high bits ignored", t | (63'h1 << 39) | (63'h1 << 62), polymod(t, 32'h07, 8));
        // R1 idle cycle
        @(negedge clk);
        check("R1 idle no valid", 64'(out_valid), 64'd0);

        // R6 generator for degree 16, with R7 interference
        @(negedge clk);
        gen_start = 1'b1;
        gen_poly  = 32'h1021;
        gen_deg   = 6'd16;
        ld_deg_we = 1'b1;
        ld_deg    = 6'd5;
        @(negedge clk);
        gen_start = 1'b0;
        ld_deg_we = 1'b0;
        busy_cycles = 0;
        while (gen_busy && busy_cycles < 40) begin
            busy_cycles++;
            if (busy_cycles == 5) begin
                ld_row_we   = 1'b1;
                ld_row_idx  = 5'd0;
                ld_row_data = 32'hDEAD;
                swap        = 1'b1;
                gen_start   = 1'b1;
                gen_deg     = 6'd4;
                gen_poly    = 32'h3;
            end else begin
                ld_row_we = 1'b0;
                swap      = 1'b0;
                gen_start = 1'b0;
            end
            @(negedge clk);
        end
        ld_row_we = 1'b0;
        swap      = 1'b0;
        gen_start = 1'b0;
        check("R6 busy cycles", 64'(busy_cycles), 64'd31);
        check("R6 done pulse", 64'(gen_done), 64'd1);
        @(negedge clk);
        check("R6 done one cycle", 64'(gen_done), 64'd0);
        // R7 swap during busy ignored: degree 8 still active
        random_checks("R7 active unchanged", 32'h07, 8, 4);
        pulse_swap();
        random_checks("R6 deg16 generated", 32'h1021, 16, 30);

        // R5 swap back restores retained bank; same-cycle swap uses old bank
        t = {$urandom, $urandom} & prod_mask(16);
        reduce(t, 1'b1);
        check("R5 same-cycle uses old", 64'(out_rem), 64'(polymod(t, 32'h1021, 16)));
        random_checks("R5 restored deg8", 32'h07, 8, 6);
        pulse_swap();
        random_checks("R5 back to deg16", 32'h1021, 16, 4);

        // R6 generator degree 32, full 63-bit products
        @(negedge clk);
        gen_start = 1'b1;
        gen_poly  = 32'h04C1_1DB7;
        gen_deg   = 6'd32;
        @(negedge clk);
        gen_start = 1'b0;
        while (gen_busy) @(negedge clk);
        pulse_swap();
        random_checks("R1 deg32", 32'h04C1_1DB7, 32, 40);
        red_check("R1 deg32 all ones", '1, polymod('1, 32'h04C1_1DB7, 32));

        // R6 random odd degree via generator
        @(negedge clk);
        gen_start = 1'b1;
        gen_poly  = 32'h0000_002B & 32'h7F;
        gen_deg   = 6'd7;
        @(negedge clk);
        gen_start = 1'b0;
        while (gen_busy) @(negedge clk);
        pulse_swap();
        random_checks("R6 deg7 generated", 32'h2B, 7, 20);

        summary();
        $finish;
    end

endmodule